// File: doc/BRIEF.md
# Dual-Reference Audio Clock Generator

This block produces the three clocks of a stereo serial audio link: a master clock, a bit clock and a left/right word clock. It also produces a one-cycle strobe that marks the start of each right half-frame. Two reference oscillators feed it. One runs at 24.576 MHz and serves the 48 kHz rate family. The other runs at 22.5792 MHz and serves the 44.1 kHz family. A three-bit rate select picks the family and a multiple of 1x, 2x or 4x of the family base rate.

The selected reference passes through a glitch-free clock multiplexer and becomes the master clock without division. A single frame counter clocked by the master clock derives the bit clock and the word clock. Every frame holds 64 bit-clock periods, 32 for the left channel and 32 for the right. When an accepted new setting arrives, the block stops the divided clocks, switches the reference if the family changed, and restarts the counter from zero. The rate select is sampled in the master-clock domain through a synchronizer, and it is accepted only when two consecutive synchronized samples agree.

The block has no data path, so none of its pins carries a handshake. All of them are plain clock, control or strobe signals.

Top module: `dual_ref_audio_clkgen`

## Requirements
- R1: While reset is asserted, all four outputs are low. After reset the block runs the 48 kHz family at 1x (select code 3'b000), and its first frame starts with the counter at zero.
- R2: Select bit 2 chooses the reference: 0 selects the 24.576 MHz input and 1 selects the 22.5792 MHz input. `mclk_o` is the chosen reference, undivided.
- R3: Select bits 1:0 give the multiple: 2'b00 = 1x, 2'b01 = 2x, 2'b10 = 4x. One bit-clock period lasts 8, 4 or 2 master-clock cycles for these multiples, so a frame lasts 512, 256 or 128 master-clock cycles.
- R4: One word-clock period holds 64 bit-clock rising edges. The word clock is low for the first 32 (left) and high for the last 32 (right).
- R5: While running, every word-clock transition happens on the same master-clock edge as a bit-clock falling edge.
- R6: `frame_start_o` is high for exactly one master-clock cycle, and that is the cycle in which the word clock first reads high.
- R7: After an accepted change, the bit clock, the word clock and the strobe are held low for at least HOLD_CYC master-clock cycles, which is at least one cycle of the old reference, before anything restarts.
- R8: A change of family switches the reference without a runt pulse on `mclk_o`. The old reference is gated off while low before the new one is gated on, so the two are never enabled together.
- R9: After every restart the counter begins at zero. The left half comes first, and exactly 32 bit-clock rising edges precede the first strobe.
- R10: A select whose bits 1:0 equal 2'b11 is ignored. The last valid setting keeps running, with no hold and no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref48_i | input | 1 | 24.576 MHz reference for the 48 kHz family |
| clk_ref44_i | input | 1 | 22.5792 MHz reference for the 44.1 kHz family |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| rate_sel_i | input | 3 | Bit 2 family, bits 1:0 multiple (R2, R3, R10) |
| mclk_o | output | 1 | Master clock, the selected reference |
| bclk_o | output | 1 | Bit clock, 64 periods per frame |
| lrck_o | output | 1 | Word clock, low for left and high for right |
| frame_start_o | output | 1 | One-cycle strobe at each word-clock rise |

## Verification
A change on the select is seen only after the synchronizer stages and one more cycle for the stability match. The hold of HOLD_CYC cycles follows, and after that come the stopped-clock interval of a reference swap and the two-stage status synchronizer. Because this latency moves with clock phases, the bench does not predict an absolute cycle for a restart. It finds the restart as a run of at least HOLD_CYC+1 samples in which both divided clocks are low, and then counts edges. The divided outputs are registered, so they change one master-clock cycle after the counter advances. The bench therefore samples every output on the falling edge of `mclk_o`, and it judges each frame, period and strobe by the number of those samples between events.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  // Multiple of the family base rate carried in select bits 1:0
  typedef enum logic [1:0] {
    MULT_1X  = 2'b00,
    MULT_2X  = 2'b01,
    MULT_4X  = 2'b10,
    MULT_BAD = 2'b11
  } mult_e;

  // Rate setting as seen on the select pins
  typedef struct packed {
    logic  fam_b;   // 1: 44.1 kHz family reference
    mult_e mult;
  } rate_cfg_t;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_HOLD,
    ST_SWAP
  } ctl_state_e;

  function automatic logic cfg_ok(rate_cfg_t c);
    return c.mult != MULT_BAD;
  endfunction

endpackage

// File: rtl/clk_sel_mux.sv
// Glitch-free two-input clock selector. A side may enable only after the
// other side is seen disabled; enables change on the falling edge of their
// own clock so the gated output is low at every switch.
module clk_sel_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic rst_n_i,
  input  logic pick_b_i,
  output logic mclk_o,
  output logic en_a_o,
  output logic en_b_o
);

  logic [1:0] clk_in;
  logic [1:0] en;

  assign clk_in = {clk_b_i, clk_a_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_side
      logic                   want;
      logic [SYNC_STAGES-1:0] sync_q;
      logic                   en_q;

      assign want = ((g == 1) ? pick_b_i : !pick_b_i) && !en[1-g];

      always_ff @(posedge clk_in[g] or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= '0;
        else          sync_q <= {sync_q[SYNC_STAGES-2:0], want};
      end

      always_ff @(negedge clk_in[g] or negedge rst_n_i) begin
        if (!rst_n_i) en_q <= 1'b0;
        else          en_q <= sync_q[SYNC_STAGES-1];
      end

      assign en[g] = en_q;
    end
  endgenerate

  assign mclk_o = (clk_a_i & en[0]) | (clk_b_i & en[1]);
  assign en_a_o = en[0];
  assign en_b_o = en[1];

endmodule

// File: rtl/rate_ctrl.sv
// Select synchronizer and the stop / swap / restart sequencer, clocked by
// the master clock.
module rate_ctrl
  import aclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 4
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic [2:0] rate_sel_i,
  input  logic       live_b_i,
  output logic       run_o,
  output logic [1:0] mult_o,
  output logic       pick_b_o
);

  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [2:0]             sel_pipe [SYNC_STAGES];
  logic [2:0]             sel_last;
  logic [SYNC_STAGES-1:0] live_pipe;
  logic                   steady;
  logic                   live_s;
  rate_cfg_t              seen;
  rate_cfg_t              cur;
  rate_cfg_t              pend;
  ctl_state_e             st;
  logic [HW-1:0]          hold_cnt;

  // Synchronize select and the mux status into this domain
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int i = 0; i < SYNC_STAGES; i++) sel_pipe[i] <= '0;
      sel_last  <= '0;
      live_pipe <= '0;
    end else begin
      sel_pipe[0] <= rate_sel_i;
      for (int i = 1; i < SYNC_STAGES; i++) sel_pipe[i] <= sel_pipe[i-1];
      sel_last  <= sel_pipe[SYNC_STAGES-1];
      live_pipe <= {live_pipe[SYNC_STAGES-2:0], live_b_i};
    end
  end

  assign seen   = rate_cfg_t'(sel_pipe[SYNC_STAGES-1]);
  assign steady = (sel_pipe[SYNC_STAGES-1] == sel_last);
  assign live_s = live_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st       <= ST_RUN;
      cur      <= rate_cfg_t'(3'b000);
      pend     <= rate_cfg_t'(3'b000);
      hold_cnt <= '0;
      pick_b_o <= 1'b0;
    end else begin
      case (st)
        ST_RUN: begin
          if (steady && cfg_ok(seen) && (seen != cur)) begin
            pend     <= seen;
            hold_cnt <= '0;
            st       <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (hold_cnt == HW'(HOLD_CYC - 1)) begin
            cur <= pend;
            if (pend.fam_b != cur.fam_b) begin
              pick_b_o <= pend.fam_b;
              st       <= ST_SWAP;
            end else begin
              st <= ST_RUN;
            end
          end else begin
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
        ST_SWAP: begin
          // wait until the new reference is confirmed live
          if (live_s == pick_b_o) st <= ST_RUN;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign run_o  = (st == ST_RUN);
  assign mult_o = cur.mult;

endmodule

// File: rtl/frame_div.sv
// Frame counter and registered bit clock, word clock and strobe.
// BASE_RATIO is master cycles per bit clock at 1x (power of two, >= 8).
module frame_div #(
  parameter int SLOT_BITS  = 32,
  parameter int BASE_RATIO = 8
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       run_i,
  input  logic [1:0] mult_i,
  output logic       bclk_o,
  output logic       lrck_o,
  output logic       fs_o
);

  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int LOG_FRAME  = $clog2(FRAME_BITS);
  localparam int LOG_BASE   = $clog2(BASE_RATIO);
  localparam int CW         = LOG_FRAME + LOG_BASE;

  logic [CW-1:0] cnt;
  logic [31:0]   cnt_w;
  int            sh;
  logic          bclk_n;
  logic          lrck_n;
  logic          wrap;
  logic          half;

  always_comb begin
    case (mult_i)
      2'b01:   sh = LOG_BASE - 1;
      2'b10:   sh = LOG_BASE - 2;
      default: sh = LOG_BASE;
    endcase
    cnt_w  = 32'(cnt);
    bclk_n = ((cnt_w >> (sh - 1)) & 32'd1) != 32'd0;
    lrck_n = ((cnt_w >> (sh + LOG_FRAME - 1)) & 32'd1) != 32'd0;
    wrap   = (cnt_w == 32'((FRAME_BITS << sh) - 1));
    half   = (cnt_w == 32'(SLOT_BITS << sh));
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt    <= '0;
      bclk_o <= 1'b0;
      lrck_o <= 1'b0;
      fs_o   <= 1'b0;
    end else if (!run_i) begin
      cnt    <= '0;
      bclk_o <= 1'b0;
      lrck_o <= 1'b0;
      fs_o   <= 1'b0;
    end else begin
      cnt    <= wrap ? '0 : cnt + 1'b1;
      bclk_o <= bclk_n;
      lrck_o <= lrck_n;
      fs_o   <= half;
    end
  end

endmodule

// File: rtl/dual_ref_audio_clkgen.sv
module dual_ref_audio_clkgen #(
  parameter int SLOT_BITS   = 32,
  parameter int BASE_RATIO  = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 4
) (
  input  logic       clk_ref48_i,
  input  logic       clk_ref44_i,
  input  logic       rst_n_i,
  input  logic [2:0] rate_sel_i,
  output logic       mclk_o,
  output logic       bclk_o,
  output logic       lrck_o,
  output logic       frame_start_o
);

  logic       pick_b_w;
  logic       en_a_w;
  logic       en_b_w;
  logic       run_w;
  logic [1:0] mult_w;

  clk_sel_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clk_a_i  (clk_ref48_i),
    .clk_b_i  (clk_ref44_i),
    .rst_n_i  (rst_n_i),
    .pick_b_i (pick_b_w),
    .mclk_o   (mclk_o),
    .en_a_o   (en_a_w),
    .en_b_o   (en_b_w)
  );

  rate_ctrl #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYC(HOLD_CYC)) u_ctrl (
    .clk_i      (mclk_o),
    .rst_n_i    (rst_n_i),
    .rate_sel_i (rate_sel_i),
    .live_b_i   (en_b_w),
    .run_o      (run_w),
    .mult_o     (mult_w),
    .pick_b_o   (pick_b_w)
  );

  frame_div #(.SLOT_BITS(SLOT_BITS), .BASE_RATIO(BASE_RATIO)) u_div (
    .clk_i   (mclk_o),
    .rst_n_i (rst_n_i),
    .run_i   (run_w),
    .mult_i  (mult_w),
    .bclk_o  (bclk_o),
    .lrck_o  (lrck_o),
    .fs_o    (frame_start_o)
  );

endmodule

// File: rtl/aclk_checker.sv
module aclk_checker (
  input logic mclk,
  input logic rst_n,
  input logic run,
  input logic bclk,
  input logic lrck,
  input logic fs,
  input logic en_a,
  input logic en_b
);

  // R7: outputs produced while stopped are low
  p_hold_low_r7: assert property (@(posedge mclk) disable iff (!rst_n)
    !$past(run) |-> (!bclk && !lrck && !fs))
    else $error("R7 divided output active during hold");

  // R9: first output after a restart comes from count zero
  p_restart_zero_r9: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(run) |=> (!bclk && !lrck))
    else $error("R9 restart not from zero");

  // R5: word clock moves only with a bit clock falling edge
  p_lr_on_fall_r5: assert property (@(posedge mclk) disable iff (!rst_n)
    ($past(run) && $past(run, 2) && (lrck != $past(lrck))) |-> ($past(bclk) && !bclk))
    else $error("R5 word clock moved off a bit clock fall");

  // R6: strobe lasts one cycle
  p_strobe_single_r6: assert property (@(posedge mclk) disable iff (!rst_n)
    fs |=> !fs)
    else $error("R6 strobe wider than one cycle");

  // R6: strobe sits on the word clock rise
  p_strobe_at_rise_r6: assert property (@(posedge mclk) disable iff (!rst_n)
    fs |-> (lrck && !$past(lrck)))
    else $error("R6 strobe away from word clock rise");

  // R8: references never enabled together
  always_comb begin
    if (rst_n) begin
      p_mux_excl_r8: assert (!(en_a && en_b))
        else $error("R8 both references enabled");
    end
  end

endmodule

bind dual_ref_audio_clkgen aclk_checker u_chk (
  .mclk  (mclk_o),
  .rst_n (rst_n_i),
  .run   (run_w),
  .bclk  (bclk_o),
  .lrck  (lrck_o),
  .fs    (frame_start_o),
  .en_a  (en_a_w),
  .en_b  (en_b_w)
);

// File: tb/dual_ref_audio_clkgen_tb.sv
`timescale 1ns/1ps
module dual_ref_audio_clkgen_tb;

  logic       clk48 = 1'b0;
  logic       clk44 = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_sel = 3'b000;
  logic       mclk, bclk, lrck, fs;

  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b0;
  int viol_lr = 0;
  int viol_fs = 0;
  int runts   = 0;
  logic p_b = 1'b0, p_l = 1'b0, p_f = 1'b0;
  realtime last_edge = 0.0;
  bit edge_seen = 1'b0;

  always #2.5 clk48 = ~clk48;   // 200 MHz bench clock, 48 kHz family
  always #2.7 clk44 = ~clk44;   // 44.1 kHz family stand-in

  dual_ref_audio_clkgen u_dut (
    .clk_ref48_i   (clk48),
    .clk_ref44_i   (clk44),
    .rst_n_i       (rst_n),
    .rate_sel_i    (rate_sel),
    .mclk_o        (mclk),
    .bclk_o        (bclk),
    .lrck_o        (lrck),
    .frame_start_o (fs)
  );

  // R5 / R6 protocol monitor, sampled on the master clock falling edge
  always @(negedge mclk) begin
    if (mon_en) begin
      if ((lrck !== p_l) && !(p_b && !bclk)) viol_lr++;
      if (fs && !(lrck && !p_l)) viol_fs++;
      if (fs && p_f) viol_fs++;
    end
    p_b = bclk;
    p_l = lrck;
    p_f = fs;
  end

  // R8 runt monitor on every master clock edge
  always @(mclk) begin
    if (edge_seen && (($realtime - last_edge) < 2.4)) runts++;
    last_edge = $realtime;
    edge_seen = 1'b1;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sync_lr_fall(output bit ok);
    logic pl;
    ok = 1'b0;
    pl = lrck;
    for (int n = 0; n < 5000; n++) begin
      @(negedge mclk);
      if (pl && !lrck) begin
        ok = 1'b1;
        break;
      end
      pl = lrck;
    end
  endtask

  // R3 / R4: one full frame counted in master cycles and bit clock rises
  task automatic measure_frame(int r, string tag);
    bit ok;
    int nm = 0, nr = 0, nl = 0;
    logic pb, pl;
    sync_lr_fall(ok);
    chk(ok, "R4", {tag, " frame boundary seen"}, int'(ok), 1);
    if (!ok) return;
    pb = bclk;
    pl = lrck;
    for (int n = 0; n < 5000; n++) begin
      @(negedge mclk);
      nm++;
      if (!pb && bclk) begin
        nr++;
        if (!lrck) nl++;
      end
      if (pl && !lrck) break;
      pb = bclk;
      pl = lrck;
    end
    chk(nm == 64 * r, "R3", {tag, " master cycles per frame"}, nm, 64 * r);
    chk(nr == 64, "R4", {tag, " bit clocks per frame"}, nr, 64);
    chk(nl == 32, "R4", {tag, " bit clocks in left half"}, nl, 32);
  endtask

  task automatic mclk_period(real exp_ns, string tag);
    realtime t1, t2;
    @(posedge mclk); t1 = $realtime;
    @(posedge mclk); t2 = $realtime;
    chk(((t2 - t1) > exp_ns - 0.05) && ((t2 - t1) < exp_ns + 0.05), "R2",
        {tag, " master clock period ps"}, int'((t2 - t1) * 1000.0), int'(exp_ns * 1000.0));
  endtask

  // R7 / R9: find the hold window, then count bit clocks to the first strobe
  task automatic await_restart(string tag);
    int low = 0, rises = 0;
    bit seen = 1'b0, got = 1'b0;
    logic pb;
    for (int n = 0; n < 20000; n++) begin
      @(negedge mclk);
      if (!bclk && !lrck) low++;
      else low = 0;
      if (low >= 5) begin
        seen = 1'b1;
        break;
      end
    end
    chk(seen, "R7", {tag, " low hold window"}, low, 5);
    if (!seen) return;
    pb = bclk;
    for (int n = 0; n < 5000; n++) begin
      @(negedge mclk);
      if (!pb && bclk) rises++;
      if (fs) begin
        got = 1'b1;
        break;
      end
      pb = bclk;
    end
    chk(got && (rises == 32), "R9", {tag, " bit clocks before first strobe"}, rises, 32);
  endtask

  task automatic set_rate(logic [2:0] v);
    @(negedge mclk);
    rate_sel = v;
  endtask

  task automatic test_reset();
    #50;
    chk(!mclk && !bclk && !lrck && !fs, "R1", "outputs low in reset",
        int'({mclk, bclk, lrck, fs}), 0);
    #53 rst_n = 1'b1;
  endtask

  task automatic test_default();
    mclk_period(5.0, "R1 default family");
    measure_frame(8, "R1 default 1x");
    mon_en = 1'b1;
  endtask

  task automatic test_same_family();
    mon_en = 1'b0;
    set_rate(3'b001);
    await_restart("48k 1x to 2x");
    mon_en = 1'b1;
    measure_frame(4, "48k 2x");
  endtask

  // R10: unsupported code must leave strobe spacing untouched
  task automatic test_bad_code();
    int gap;
    for (int n = 0; n < 5000; n++) begin
      @(negedge mclk);
      if (fs) break;
    end
    rate_sel = 3'b011;
    for (int k = 0; k < 3; k++) begin
      gap = 0;
      for (int n = 0; n < 5000; n++) begin
        @(negedge mclk);
        gap++;
        if (fs) break;
      end
      chk(gap == 256, "R10", "strobe spacing after bad code", gap, 256);
    end
  endtask

  task automatic test_family_swap();
    mon_en = 1'b0;
    set_rate(3'b100);
    await_restart("swap to 44k 1x");
    mon_en = 1'b1;
    mclk_period(5.4, "44k family");
    measure_frame(8, "44k 1x");
  endtask

  task automatic test_4x();
    mon_en = 1'b0;
    set_rate(3'b110);
    await_restart("44k 4x");
    mon_en = 1'b1;
    measure_frame(2, "44k 4x");
  endtask

  task automatic test_swap_back();
    mon_en = 1'b0;
    set_rate(3'b010);
    await_restart("swap to 48k 4x");
    mon_en = 1'b1;
    mclk_period(5.0, "48k family again");
    measure_frame(2, "48k 4x");
  endtask

  task automatic final_checks();
    chk(viol_lr == 0, "R5", "word clock changes off bit clock fall", viol_lr, 0);
    chk(viol_fs == 0, "R6", "strobe placement or width faults", viol_fs, 0);
    chk(runts == 0, "R8", "master clock runt pulses", runts, 0);
  endtask

  initial begin
    test_reset();
    test_default();
    test_same_family();
    test_bad_code();
    test_family_swap();
    test_4x();
    test_swap_back();
    final_checks();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    checks++;
    fails++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule